// File: doc/BRIEF.md
# Two-Event Interval Timing Gate

This block measures the time between two asynchronous events, such as a switch closing and a flash picked up by a light sensor. Each of the two event inputs passes through its own polarity stage, which can pass the signal as it is or invert it. The conditioned signal then sets a sticky capture latch. A capture latch sets on the edge itself, with no clock involved, so a pulse much shorter than a clock period is still caught. The latch stays set until the clear input is asserted.

The latch states are synchronized into the clock domain. While exactly one latch is set, the free-running clock is passed to a gated clock output and an internal counter advances once per cycle. The count therefore covers the span from the first event to the second, whichever input fires first. When the second latch sets, counting stops and the value holds until the next clear. The counter stops at its maximum instead of wrapping.

To measure the length of one pulse, tie both event inputs to that pulse and give them opposite polarities. The leading edge then sets one latch and the trailing edge sets the other.

Top module: `interval_gate`

## Requirements
- R1: While rst_n is low, and after it is released with no event, armed_a, armed_b, active and done are 0, count is 0 and gclk_out is low.
- R2: The conditioned input is evt XOR inv. Its latch sets on a rising edge of the conditioned input. With inv=0 a low-to-high event sets the latch. With inv=1 a high-to-low event sets it, and a low-to-high edge leaves it clear.
- R3: An event pulse shorter than one clock period, arriving between clock edges, sets its latch. armed_a or armed_b goes high at once, without waiting for a clock edge.
- R4: A set latch stays set through later edges of its input. Asserting clr clears both latches at once.
- R5: active is high while exactly one synchronized latch is set, and count advances by one on each such clock edge. If the first event arrives in the cycle before clock edge k and the second in the cycle before edge k+N, count ends at N. This holds for either input order.
- R6: While active is high, gclk_out follows clk. While active is low, gclk_out stays low.
- R7: done goes high once both latches are set. From then on, count holds its value until clr.
- R8: count stops at 2^CNT_W-1 and does not wrap, while active stays high.
- R9: An event edge that arrives while clr is high does not set its latch (clear wins).
- R10: With both event inputs driven by one signal, inv_a=0 and inv_b=1, a high pulse that starts in the cycle before edge k and ends in the cycle before edge k+P leaves count equal to P.
- R11: While clr is high, count is 0 and active and done are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running counting clock |
| rst_n | input | 1 | Active-low reset, clears all state |
| evt_a | input | 1 | First event input |
| evt_b | input | 1 | Second event input |
| inv_a | input | 1 | Polarity select for evt_a (1 = falling-edge event) |
| inv_b | input | 1 | Polarity select for evt_b (1 = falling-edge event) |
| clr | input | 1 | Clears both latches and the counter |
| gclk_out | output | 1 | Clock passed through while timing |
| armed_a | output | 1 | Latch A has been triggered |
| armed_b | output | 1 | Latch B has been triggered |
| active | output | 1 | Exactly one latch set, timing in progress |
| done | output | 1 | Both latches set |
| count | output | CNT_W | Measured interval in clock cycles |

## Verification
Latch status is combinational from the event edge, so it is checked a nanosecond after the edge is driven. active, done and count sit two synchronizer flops plus one counter register behind a latch. Every event is driven on a falling clock edge, and count is compared three rising edges after the second event, when the final value N has settled. gclk_out is sampled two nanoseconds after a rising edge, while clk is high, at least three edges into an interval, so the falling-edge enable flop has already opened the gate. The scoreboard queues each expected value at the moment the stimulus makes it due, so the monitor compares only settled outputs.

// File: rtl/interval_gate.sv
module interval_gate #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_a,
  input  logic             evt_b,
  input  logic             inv_a,
  input  logic             inv_b,
  input  logic             clr,
  output logic             gclk_out,
  output logic             armed_a,
  output logic             armed_b,
  output logic             active,
  output logic             done,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] MAXV = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};

  logic wipe;
  logic cond_a, cond_b;
  logic lat_a, lat_b;
  logic [1:0] sync_a, sync_b;
  logic run, run_n;

  assign wipe   = clr | ~rst_n;
  assign cond_a = evt_a ^ inv_a;
  assign cond_b = evt_b ^ inv_b;

  always_ff @(posedge cond_a or posedge wipe)
    if (wipe) lat_a <= 1'b0;
    else      lat_a <= 1'b1;

  always_ff @(posedge cond_b or posedge wipe)
    if (wipe) lat_b <= 1'b0;
    else      lat_b <= 1'b1;

  always_ff @(posedge clk or posedge wipe)
    if (wipe) begin
      sync_a <= 2'b00;
      sync_b <= 2'b00;
    end else begin
      sync_a <= {sync_a[0], lat_a};
      sync_b <= {sync_b[0], lat_b};
    end

  assign run  = sync_a[1] ^ sync_b[1];
  assign done = sync_a[1] & sync_b[1];

  always_ff @(negedge clk or posedge wipe)
    if (wipe) run_n <= 1'b0;
    else      run_n <= run;

  assign gclk_out = ~(~(clk & run_n));

  always_ff @(posedge clk or posedge wipe)
    if (wipe)                     count <= '0;
    else if (run && count != MAXV) count <= count + ONE;

  assign armed_a = lat_a;
  assign armed_b = lat_b;
  assign active  = run;

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (active && count != MAXV) |=> (clr || count == $past(count) + ONE));

  assert_done_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (clr || $stable(count)));

  assert_no_wrap_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (count == MAXV) |=> (clr || count == MAXV));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr |-> (count == '0 && !active && !done));

endmodule

// File: tb/sim_interval_gate.sv
module sim_interval_gate;
  localparam int W = 8;

  logic clk = 0, rst_n = 0;
  logic evt_a = 0, evt_b = 0, inv_a = 0, inv_b = 0, clr = 0;
  logic gclk_out, armed_a, armed_b, active, done;
  logic [W-1:0] count;

  interval_gate #(.CNT_W(W)) u0 (.*);

  always #5 clk = ~clk;

  typedef struct { string req; int sel; int exp; } item_t;
  item_t sb[$];
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  function automatic int probe(int sel);
    case (sel)
      0: return int'(count);
      1: return int'(armed_a);
      2: return int'(armed_b);
      3: return int'(active);
      4: return int'(done);
      default: return int'(gclk_out);
    endcase
  endfunction

  function automatic void expect_val(string req, int sel, int exp);
    item_t it;
    it.req = req; it.sel = sel; it.exp = exp;
    sb.push_back(it);
  endfunction

  initial forever begin
    item_t it;
    int act;
    wait (sb.size() > 0);
    it = sb.pop_front();
    act = probe(it.sel);
    n_chk++;
    if (act != it.exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%0d expected=%0d", it.req, it.sel, act, it.exp);
    end
  end

  task automatic at_neg();
    @(negedge clk); #1;
  endtask

  task automatic at_pos(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic clear(logic ia, logic ib, logic ea, logic eb);
    at_neg();
    clr = 1; inv_a = ia; inv_b = ib; evt_a = ea; evt_b = eb;
    at_pos(1);
    expect_val("R11", 0, 0);
    expect_val("R4", 1, 0);
    expect_val("R4", 2, 0);
    expect_val("R11", 3, 0);
    at_neg();
    clr = 0;
    at_pos(2);
  endtask

  task automatic interval(int n, bit a_first);
    clear(0, 0, 0, 0);
    at_neg();
    if (a_first) evt_a = 1; else evt_b = 1;
    #1;
    expect_val("R3", a_first ? 1 : 2, 1);
    expect_val("R3", a_first ? 2 : 1, 0);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      if (i == 2) begin
        #2;
        expect_val("R5", 3, 1);
        expect_val("R6", 5, 1);
      end
    end
    at_neg();
    if (a_first) evt_b = 1; else evt_a = 1;
    at_pos(3);
    expect_val("R5", 0, n);
    expect_val("R7", 4, 1);
    expect_val("R5", 3, 0);
    at_pos(10);
    expect_val("R7", 0, n);
    expect_val("R6", 5, 0);
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #1;
    expect_val("R1", 1, 0);
    expect_val("R1", 0, 0);
    at_pos(3);
    at_neg();
    rst_n = 1;
    at_pos(3);
    expect_val("R1", 0, 0);
    expect_val("R1", 1, 0);
    expect_val("R1", 2, 0);
    expect_val("R1", 3, 0);
    expect_val("R1", 4, 0);
    expect_val("R1", 5, 0);

    interval(7, 1);
    interval(5, 0);
    interval(1, 1);

    // R2: inverted polarity, rising edge ignored, falling edge sets
    clear(1, 1, 0, 1);
    at_neg(); evt_a = 1; #1;
    expect_val("R2", 1, 0);
    at_neg(); evt_a = 0; #1;
    expect_val("R2", 1, 1);
    at_neg(); evt_a = 1; #1; evt_a = 0; #1;
    expect_val("R4", 1, 1);
    at_neg(); evt_b = 0; #1;
    expect_val("R2", 2, 1);
    at_pos(3);
    expect_val("R7", 4, 1);

    // R3: sub-period pulse between clock edges
    clear(0, 0, 0, 0);
    at_neg(); evt_b = 1; #1; evt_b = 0; #1;
    expect_val("R3", 2, 1);
    at_pos(4);
    expect_val("R3", 3, 1);

    // R9: event during clear is ignored
    clear(0, 0, 0, 0);
    at_neg(); clr = 1; #1; evt_a = 1; #1;
    expect_val("R9", 1, 0);
    at_neg(); clr = 0; #1;
    expect_val("R9", 1, 0);
    at_pos(4);
    expect_val("R9", 0, 0);
    expect_val("R9", 3, 0);

    // R10: linked inputs measure pulse length
    clear(0, 1, 0, 0);
    at_neg(); evt_a = 1; evt_b = 1; #1;
    expect_val("R10", 1, 1);
    expect_val("R10", 2, 0);
    repeat (9) @(posedge clk);
    at_neg(); evt_a = 0; evt_b = 0;
    at_pos(3);
    expect_val("R10", 0, 9);
    expect_val("R10", 4, 1);

    // R8: saturation
    clear(0, 0, 0, 0);
    at_neg(); evt_a = 1;
    at_pos(300);
    expect_val("R8", 0, 255);
    expect_val("R8", 3, 1);
    at_neg(); evt_b = 1;
    at_pos(4);
    expect_val("R8", 0, 255);

    // R11: clear empties counter
    clear(0, 0, 0, 0);
    expect_val("R11", 0, 0);
    expect_val("R11", 4, 0);

    at_pos(2);
    wait (sb.size() == 0);
    #1;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule